// File: doc/BRIEF.md
# Color-Keyed Binary Mask Pipeline

This block turns a raster of 16-bit RGB pixels into a one-bit mask that marks where a single chosen color appears. Every incoming pixel is folded into an 8-bit code: a 4-bit color class and a 4-bit gray level. Only pixels whose class equals the selected target class keep their gray level; all others continue as gray 0. The kept gray levels are smoothed with a 3x3 box average, and the average is compared against a threshold to produce the mask bit.

Pixels arrive on a valid/ready stream with a frame-start flag on the first pixel. Mask bits leave on a second valid/ready stream, one per input pixel in raster order, tagged with frame-start and end-of-line flags. The frame width and height, the target class and the threshold are taken from configuration inputs when a frame begins. The window is built from a three-row ring of gray levels, so a frame may be any height up to `MAX_H` and any width up to `MAX_W`.

Top module: `color_key_mask`

## Requirements
- R1: With the pixel split as red = bits 15:11, green = bits 10:5, blue = bits 4:0, the class is {red[4], green[5], blue[4], red[3] | green[4] | blue[3]} (MSB first) and the gray level is (red + green + blue) >> 3.
- R2: A pixel whose class differs from the target class contributes gray 0 to every window it falls in, whatever its own gray level.
- R3: Each mask bit uses the mean floor(S/9), where S is the sum of the 3x3 neighbourhood of gray levels around the pixel; rows above the top or below the bottom repeat the nearest row, and columns beyond either edge repeat the nearest column.
- R4: The mask bit is 1 exactly when that mean is greater than or equal to the threshold; a threshold of 0 marks every pixel.
- R5: A frame of W x H pixels yields exactly W*H mask bits, in raster order, and no bit is produced before the pixels its window needs have been accepted.
- R6: `out_sof` is 1 only on the first mask bit of a frame and `out_eol` is 1 only on the last mask bit of each line.
- R7: Width, height, target class and threshold are captured when the frame-start pixel is accepted; changing the configuration inputs during a frame has no effect on that frame.
- R8: While no frame is in progress, `in_ready` is 1 and pixels without the frame-start flag are accepted and dropped without producing any mask bit.
- R9: While `out_valid` is 1 and `out_ready` is 0, the mask bit and both flags hold their values and `out_valid` stays 1.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.
- R11: Frames one pixel wide, one line high, or both, are handled with the same edge repetition rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_pix | input | 16 | RGB pixel, 5/6/5 bits |
| in_sof | input | 1 | Marks the first pixel of a frame |
| cfg_width | input | $clog2(MAX_W+1) | Pixels per line, 1 to MAX_W |
| cfg_height | input | $clog2(MAX_H+1) | Lines per frame, 1 to MAX_H |
| cfg_class | input | 4 | Target color class |
| cfg_thresh | input | 4 | Mask threshold on the 3x3 mean |
| out_valid | output | 1 | Mask bit present |
| out_ready | input | 1 | Consumer takes the mask bit this cycle |
| out_mask | output | 1 | Mask bit |
| out_sof | output | 1 | First mask bit of the frame |
| out_eol | output | 1 | Last mask bit of a line |

## Verification
Single-pixel frames with the threshold set at and one above the computed gray level pin down the class and gray mapping on their own, since the window then averages nine copies of one value. Uniform frames separate the reciprocal scaling from the window logic, frames of stray bright pixels of a foreign class show whether discarded pixels leak into the sums, and random frames of thin, flat and full-width shapes probe the edge repetition and the three-row ring under input gaps and output backpressure. A mid-frame configuration change and stray pixels sent between frames show that only the captured settings and only the framed pixels reach the mask.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

   localparam int PIX_W  = 16;
   localparam int CLS_W  = 4;
   localparam int GRAY_W = 4;
   localparam int TAPS   = 9;
   localparam int ROWS   = 3;

   typedef logic [CLS_W-1:0]  cls_t;
   typedef logic [GRAY_W-1:0] gray_t;
   typedef logic [1:0]        slot_t;

   // ring slot arithmetic modulo the number of stored rows
   function automatic slot_t slot_inc(slot_t s);
      return (s == slot_t'(ROWS-1)) ? slot_t'(0) : s + slot_t'(1);
   endfunction

   function automatic slot_t slot_dec(slot_t s);
      return (s == slot_t'(0)) ? slot_t'(ROWS-1) : s - slot_t'(1);
   endfunction

endpackage

// File: rtl/ckm_quant.sv
module ckm_quant
   import ckm_pkg::*;
(
   input  logic [PIX_W-1:0] pix,
   input  cls_t             target,
   output gray_t            gray_sel
);

   logic [4:0] red;
   logic [5:0] grn;
   logic [4:0] blu;
   logic [6:0] lum;
   cls_t       cls;
   gray_t      gray_raw;

   always_comb begin
      red      = pix[15:11];
      grn      = pix[10:5];
      blu      = pix[4:0];
      lum      = {2'b00, red} + {1'b0, grn} + {2'b00, blu};
      gray_raw = GRAY_W'(lum >> 3);
      cls      = {red[4], grn[5], blu[4], red[3] | grn[4] | blu[3]};
      gray_sel = (cls == target) ? gray_raw : '0;
   end

endmodule

// File: rtl/ckm_row_ring.sv
module ckm_row_ring
   import ckm_pkg::*;
#(
   parameter int MAX_W = 64,
   localparam int CW   = $clog2(MAX_W)
)(
   input  logic                 clk,
   input  logic                 wr_en,
   input  slot_t                wr_slot,
   input  logic [CW-1:0]        wr_col,
   input  gray_t                wr_data,
   input  slot_t [2:0]          rd_slot,
   input  logic  [2:0][CW-1:0]  rd_col,
   output gray_t [TAPS-1:0]     taps
);

   gray_t mem [ROWS][MAX_W];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_slot][wr_col] <= wr_data;
   end

   for (genvar r = 0; r < 3; r++) begin : g_row
      for (genvar c = 0; c < 3; c++) begin : g_col
         assign taps[r*3 + c] = mem[rd_slot[r]][rd_col[c]];
      end
   end

endmodule

// File: rtl/ckm_box_mean.sv
module ckm_box_mean
   import ckm_pkg::*;
#(
   parameter int MEAN_SHIFT = 9,
   parameter bit EXACT_DIV  = 1'b0
)(
   input  gray_t [TAPS-1:0] taps,
   input  gray_t            thresh,
   output logic             mask
);

   localparam int SUM_W   = $clog2(TAPS * (2**GRAY_W - 1) + 1);
   localparam int MAX_SUM = TAPS * (2**GRAY_W - 1);
   localparam int RECIP   = (2**MEAN_SHIFT + TAPS - 1) / TAPS;
   localparam int PROD_W  = SUM_W + MEAN_SHIFT;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] mean_v;

   always_comb begin
      sum = '0;
      for (int i = 0; i < TAPS; i++) sum = sum + SUM_W'(taps[i]);
   end

   if (EXACT_DIV) begin : g_div
      assign mean_v = sum / SUM_W'(TAPS);
   end else begin : g_recip
      if (MEAN_SHIFT > 16)
         $error("MEAN_SHIFT too large for the reciprocal product");
      if (MAX_SUM * (TAPS * RECIP - 2**MEAN_SHIFT) >= 2**MEAN_SHIFT)
         $error("MEAN_SHIFT too small for an exact floor of sum/9");
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(sum) * PROD_W'(RECIP);
      assign mean_v = SUM_W'(prod >> MEAN_SHIFT);
   end

   assign mask = (mean_v >= SUM_W'(thresh));

endmodule

// File: rtl/color_key_mask.sv
module color_key_mask
   import ckm_pkg::*;
#(
   parameter int MAX_W      = 64,
   parameter int MAX_H      = 1024,
   parameter int MEAN_SHIFT = 9,
   parameter bit EXACT_DIV  = 1'b0,
   localparam int WW        = $clog2(MAX_W + 1),
   localparam int HW        = $clog2(MAX_H + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [15:0]   in_pix,
   input  logic          in_sof,
   input  logic [WW-1:0] cfg_width,
   input  logic [HW-1:0] cfg_height,
   input  logic [3:0]    cfg_class,
   input  logic [3:0]    cfg_thresh,
   output logic          out_valid,
   input  logic          out_ready,
   output logic          out_mask,
   output logic          out_sof,
   output logic          out_eol
);

   localparam int CW = $clog2(MAX_W);

   if (MAX_W < 2) $error("MAX_W must be at least 2");
   if (MAX_H < 1) $error("MAX_H must be at least 1");

   // captured frame settings
   logic          act_q;
   logic [WW-1:0] w_q;
   logic [HW-1:0] h_q;
   cls_t          cls_q;
   gray_t         thr_q;

   // write and read positions
   logic [HW-1:0] ri_q, ro_q;
   logic [WW-1:0] ci_q, co_q;
   slot_t         islot_q, oslot_q;

   logic          accept, start, wr_en;
   logic [WW-1:0] cur_w;
   cls_t          cls_use;
   logic [HW-1:0] nxt_ri;
   logic [WW-1:0] nxt_ci;
   slot_t         nxt_slot;
   gray_t         gray_sel;

   logic [HW:0]   ri_ext, ro_plus2;

   logic          last_col, last_row, avail, load;
   logic [HW-1:0] rn;
   logic [WW-1:0] cn;
   slot_t [2:0]         rd_slot;
   logic  [2:0][CW-1:0] rd_col;
   gray_t [TAPS-1:0]    taps;
   logic                mask_c;

   // ---------------- input side ----------------
   assign ri_ext   = {1'b0, ri_q};
   assign ro_plus2 = {1'b0, ro_q} + (HW+1)'(2);
   assign in_ready = !act_q || ((ri_q < h_q) && (ri_ext != ro_plus2));
   assign accept   = in_valid && in_ready;
   assign start    = accept && !act_q && in_sof;
   assign wr_en    = accept && (act_q || in_sof);

   always_comb begin
      cur_w   = act_q ? w_q   : cfg_width;
      cls_use = act_q ? cls_q : cfg_class;
      if (ci_q == cur_w - 1'b1) begin
         nxt_ci   = '0;
         nxt_ri   = ri_q + 1'b1;
         nxt_slot = slot_inc(islot_q);
      end else begin
         nxt_ci   = ci_q + 1'b1;
         nxt_ri   = ri_q;
         nxt_slot = islot_q;
      end
   end

   ckm_quant u_quant (
      .pix      (in_pix),
      .target   (cls_use),
      .gray_sel (gray_sel)
   );

   ckm_row_ring #(.MAX_W(MAX_W)) u_ring (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_slot (islot_q),
      .wr_col  (ci_q[CW-1:0]),
      .wr_data (gray_sel),
      .rd_slot (rd_slot),
      .rd_col  (rd_col),
      .taps    (taps)
   );

   // ---------------- output side ----------------
   always_comb begin
      last_col = (co_q == w_q - 1'b1);
      last_row = (ro_q == h_q - 1'b1);
      rn       = last_row ? ro_q : ro_q + 1'b1;
      cn       = last_col ? co_q : co_q + 1'b1;
      avail    = act_q && ((ri_q > rn) || ((ri_q == rn) && (ci_q > cn)));
      load     = avail && (!out_valid || out_ready);

      rd_slot[0] = (ro_q == '0) ? oslot_q : slot_dec(oslot_q);
      rd_slot[1] = oslot_q;
      rd_slot[2] = last_row ? oslot_q : slot_inc(oslot_q);

      rd_col[0]  = CW'((co_q == '0) ? co_q : co_q - 1'b1);
      rd_col[1]  = CW'(co_q);
      rd_col[2]  = CW'(cn);
   end

   ckm_box_mean #(
      .MEAN_SHIFT (MEAN_SHIFT),
      .EXACT_DIV  (EXACT_DIV)
   ) u_mean (
      .taps   (taps),
      .thresh (thr_q),
      .mask   (mask_c)
   );

   // ---------------- state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         w_q       <= '0;
         h_q       <= '0;
         cls_q     <= '0;
         thr_q     <= '0;
         ri_q      <= '0;
         ci_q      <= '0;
         islot_q   <= '0;
         ro_q      <= '0;
         co_q      <= '0;
         oslot_q   <= '0;
         out_valid <= 1'b0;
         out_mask  <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
      end else begin
         if (start) begin
            act_q <= 1'b1;
            w_q   <= cfg_width;
            h_q   <= cfg_height;
            cls_q <= cfg_class;
            thr_q <= cfg_thresh;
         end
         if (wr_en) begin
            ri_q    <= nxt_ri;
            ci_q    <= nxt_ci;
            islot_q <= nxt_slot;
         end
         if (load) begin
            out_valid <= 1'b1;
            out_mask  <= mask_c;
            out_sof   <= (ro_q == '0) && (co_q == '0);
            out_eol   <= last_col;
            if (last_col) begin
               co_q <= '0;
               if (last_row) begin
                  ro_q    <= '0;
                  oslot_q <= '0;
                  act_q   <= 1'b0;
                  ri_q    <= '0;
                  ci_q    <= '0;
                  islot_q <= '0;
               end else begin
                  ro_q    <= ro_q + 1'b1;
                  oslot_q <= slot_inc(oslot_q);
               end
            end else begin
               co_q <= co_q + 1'b1;
            end
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ckm_chk.sv
module ckm_chk #(
   parameter int WW = 7,
   parameter int HW = 11
)(
   input logic          clk,
   input logic          rst_n,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic          out_mask,
   input logic          out_sof,
   input logic          out_eol,
   input logic          wr_en,
   input logic          act_q,
   input logic [WW-1:0] w_q,
   input logic [HW-1:0] h_q,
   input logic [3:0]    cls_q,
   input logic [3:0]    thr_q
);

   logic [WW-1:0] lcnt;
   logic [31:0]   icnt, ocnt;
   logic          o_hs;

   assign o_hs = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt <= '0;
         icnt <= '0;
         ocnt <= '0;
      end else begin
         if (wr_en) icnt <= icnt + 32'd1;
         if (o_hs) begin
            ocnt <= ocnt + 32'd1;
            lcnt <= out_eol ? '0 : lcnt + 1'b1;
         end
      end
   end

   assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)
                                     && $stable(out_sof) && $stable(out_eol)));

   assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
      o_hs |-> (ocnt < icnt));

   assert_eol_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_hs && out_eol) |-> (lcnt == w_q - 1'b1));

   assert_eol_only_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_hs && !out_eol) |-> (lcnt < w_q - 1'b1));

   assert_sof_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_hs && out_sof) |-> (lcnt == '0));

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && $past(act_q)) |-> ($stable(w_q) && $stable(h_q)
                                   && $stable(cls_q) && $stable(thr_q)));

endmodule

bind color_key_mask ckm_chk #(.WW(WW), .HW(HW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_mask  (out_mask),
   .out_sof   (out_sof),
   .out_eol   (out_eol),
   .wr_en     (wr_en),
   .act_q     (act_q),
   .w_q       (w_q),
   .h_q       (h_q),
   .cls_q     (cls_q),
   .thr_q     (thr_q)
);

// File: tb/color_key_mask_tb_top.sv
module color_key_mask_tb_top;

   localparam int MW = 64;
   localparam int MH = 1024;
   localparam int WW = $clog2(MW + 1);
   localparam int HW = $clog2(MH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          in_valid, in_ready, in_sof;
   logic [15:0]   in_pix;
   logic [WW-1:0] cfg_width;
   logic [HW-1:0] cfg_height;
   logic [3:0]    cfg_class, cfg_thresh;
   logic          out_valid, out_ready, out_mask, out_sof, out_eol;

   color_key_mask #(.MAX_W(MW), .MAX_H(MH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof),
      .cfg_width(cfg_width), .cfg_height(cfg_height),
      .cfg_class(cfg_class), .cfg_thresh(cfg_thresh),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_mask(out_mask), .out_sof(out_sof), .out_eol(out_eol)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int got     = 0;
   string cur_tag = "R4";
   logic [2:0] exp_q[$];
   logic       hold_v = 1'b0;
   logic [2:0] hold_val;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp,
                        input string what);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // requirement R1 mapping, written from the field layout
   function automatic logic [3:0] cls_of(logic [15:0] p);
      return {p[15], p[10], p[4], p[14] | p[9] | p[3]};
   endfunction

   function automatic int gray_of(logic [15:0] p);
      return (int'(p[15:11]) + int'(p[10:5]) + int'(p[4:0])) / 8;
   endfunction

   function automatic logic [15:0] force_cls(logic [15:0] p, logic [3:0] c);
      logic [15:0] q = p;
      q[15] = c[3]; q[10] = c[2]; q[4] = c[1];
      if (c[0]) q[14] = 1'b1;
      else begin q[14] = 1'b0; q[9] = 1'b0; q[3] = 1'b0; end
      return q;
   endfunction

   task automatic gen(output logic [15:0] q[$], input int n, input logic [3:0] c,
                      input int dens);
      q = {};
      for (int i = 0; i < n; i++) begin
         logic [15:0] p = 16'($urandom);
         if (int'($urandom % 100) < dens) p = force_cls(p, c);
         q.push_back(p);
      end
   endtask

   // output monitor: sampled at the falling edge, transfer happens at the next rise
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_v)
            check(out_valid && ({out_mask, out_sof, out_eol} == hold_val), "R9",
                  int'({out_valid, out_mask, out_sof, out_eol}), int'({1'b1, hold_val}),
                  "held output");
         out_ready = ($urandom % 4) != 0;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5", 1, 0, "unexpected mask bit");
            end else begin
               logic [2:0] e;
               e = exp_q.pop_front();
               check(out_mask == e[2], cur_tag, int'(out_mask), int'(e[2]), "mask bit");
               check({out_sof, out_eol} == e[1:0], "R6", int'({out_sof, out_eol}),
                     int'(e[1:0]), "frame/line flags");
            end
            got++;
         end
         hold_v   = out_valid && !out_ready;
         hold_val = {out_mask, out_sof, out_eol};
      end
   end

   task automatic send(input logic [15:0] p, input logic sof);
      bit acc;
      in_valid = 1'b1; in_pix = p; in_sof = sof;
      do begin
         acc = in_ready;
         @(negedge clk);
      end while (!acc);
      in_valid = 1'b0; in_sof = 1'b0;
   endtask

   task automatic run_frame(input int w, input int h, input logic [3:0] cls,
                            input logic [3:0] thr, input logic [15:0] px[$],
                            input string tag, input bit gaps, input bit midchg);
      int sel[];
      sel = new[w*h];
      for (int i = 0; i < w*h; i++)
         sel[i] = (cls_of(px[i]) == cls) ? gray_of(px[i]) : 0;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c++) begin
            int s = 0;
            logic b, fs, fe;
            for (int dr = -1; dr <= 1; dr++) begin
               for (int dc = -1; dc <= 1; dc++) begin
                  int rr = r + dr;
                  int cc = c + dc;
                  if (rr < 0) rr = 0;
                  if (rr > h-1) rr = h-1;
                  if (cc < 0) cc = 0;
                  if (cc > w-1) cc = w-1;
                  s += sel[rr*w + cc];
               end
            end
            b  = (s / 9) >= int'(thr);
            fs = (r == 0) && (c == 0);
            fe = (c == w-1);
            exp_q.push_back({b, fs, fe});
         end
      end
      cur_tag = tag;
      got = 0;
      cfg_width = WW'(w); cfg_height = HW'(h); cfg_class = cls; cfg_thresh = thr;
      for (int i = 0; i < w*h; i++) begin
         send(px[i], i == 0);
         if (i == 0 && midchg) begin
            cfg_width = WW'(3); cfg_height = HW'(2);
            cfg_class = ~cls; cfg_thresh = ~thr;
         end
         if (gaps) repeat ($urandom % 3) @(negedge clk);
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check(got == w*h, "R5", got, w*h, "mask bit count");
      check(!out_valid, "R5", int'(out_valid), 0, "no extra mask bit");
   endtask

   task automatic run_all();
      logic [15:0] q[$];
      // R1 and R11: single-pixel frames, threshold at and above the gray level
      for (int k = 0; k < 12; k++) begin
         logic [15:0] p;
         int g;
         p = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'($urandom);
         g = gray_of(p);
         run_frame(1, 1, cls_of(p), 4'(g), {p}, "R1", 0, 0);
         if (g < 15) run_frame(1, 1, cls_of(p), 4'(g + 1), {p}, "R1", 0, 0);
      end
      // R11: thin and flat frames
      gen(q, 5, 4'd6, 60);   run_frame(1, 5, 4'd6, 4'd2, q, "R11", 1, 0);
      gen(q, 7, 4'd9, 60);   run_frame(7, 1, 4'd9, 4'd3, q, "R11", 1, 0);
      gen(q, 4, 4'd3, 70);   run_frame(2, 2, 4'd3, 4'd2, q, "R11", 0, 0);
      // R3: uniform frames make every mean equal the pixel gray
      begin
         logic [15:0] p;
         int g;
         p = force_cls(16'hB6D5, 4'd13);
         g = gray_of(p);
         q = {};
         for (int i = 0; i < 20; i++) q.push_back(p);
         run_frame(5, 4, 4'd13, 4'(g), q, "R3", 1, 0);
         if (g < 15) run_frame(5, 4, 4'd13, 4'(g + 1), q, "R3", 0, 0);
      end
      gen(q, 48, 4'd5, 55);  run_frame(8, 6, 4'd5, 4'd3, q, "R3", 1, 0);
      gen(q, 60, 4'd11, 50); run_frame(10, 6, 4'd11, 4'd4, q, "R3", 0, 0);
      // R2: bright foreign-class pixels must not lift the mean
      q = {};
      for (int i = 0; i < 42; i++)
         q.push_back((($urandom % 2) == 0) ? 16'hFFFF : force_cls(16'($urandom), 4'd2));
      run_frame(7, 6, 4'd2, 4'd2, q, "R2", 1, 0);
      // R4: threshold extremes
      gen(q, 30, 4'd7, 40);  run_frame(6, 5, 4'd7, 4'd0, q, "R4", 0, 0);
      q = {};
      for (int i = 0; i < 30; i++)
         q.push_back((($urandom % 4) == 0) ? force_cls(16'h0000, 4'd15)
                                           : force_cls(16'hFFFF, 4'd15));
      run_frame(6, 5, 4'd15, 4'd15, q, "R4", 1, 0);
      // full width with gaps and backpressure
      gen(q, MW*4, 4'd12, 50); run_frame(MW, 4, 4'd12, 4'd3, q, "R4", 1, 0);
      // R7: configuration changed right after the frame-start pixel
      gen(q, 30, 4'd4, 60);  run_frame(6, 5, 4'd4, 4'd3, q, "R7", 1, 1);
      // R8: stray pixels before the frame-start pixel
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_sof = 1'b0; in_pix = 16'hFFFF;
         check(in_ready, "R8", int'(in_ready), 1, "ready while idle");
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check(!out_valid, "R8", int'(out_valid), 0, "no output from stray pixels");
      end
      gen(q, 20, 4'd15, 50); run_frame(5, 4, 4'd15, 4'd4, q, "R8", 0, 0);
      // R6: back-to-back frames of varied shapes
      for (int f = 0; f < 4; f++) begin
         int w = 2 + f * 3;
         int h = 3 + f;
         logic [3:0] c = 4'($urandom);
         gen(q, w*h, c, 60);
         run_frame(w, h, c, 4'(1 + f), q, "R6", f[0], 0);
      end
   endtask

   initial begin
      in_valid = 1'b0; in_sof = 1'b0; in_pix = '0; out_ready = 1'b0;
      cfg_width = WW'(4); cfg_height = HW'(4); cfg_class = '0; cfg_thresh = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(!out_valid, "R10", int'(out_valid), 0, "out_valid after reset");
      check(in_ready, "R10", int'(in_ready), 1, "in_ready after reset");
      fork
         run_all();
         begin
            while (cyc < 150000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog: got %0d expected %0d", cyc, 150000);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule